// File: doc/BRIEF.md
# Logic and Negate Flag Unit

This execution unit combines a 32-bit accumulator with a second operand by bitwise AND, OR or XOR. It also forms the two's-complement negation (zero minus operand) of the operand's low byte or low half-word. A three-bit operation select picks the function. The current condition flags N, Z, V and C come in on a 4-bit input, and the unit registers the result together with the updated flags.

A valid strobe marks the cycle in which new flags and a new result appear. Each operation class updates the flags by its own rule. The logic functions set N and Z from the result, force V low and pass C through unchanged. Negation derives all four flags from the subtraction. Idle and reserved select codes leave every registered output untouched.

Top module: `logic_neg_flag_unit`

## Requirements
- R1: opSel codes are 3'b001 AND, 3'b010 OR and 3'b011 XOR of accIn with operandIn. The 32-bit result appears on resultOut at the clock edge that samples the code.
- R2: After a logic function, flagsOut is {N,Z,V,C} with bit 3 = N. N is result bit 31, Z is 1 exactly when the 32-bit result is zero, and V is 0.
- R3: After a logic function, flagsOut bit 0 (C) equals flagsIn bit 0 sampled with the operation.
- R4: opSel 3'b100 is byte negation. resultOut = {24'b0, (0 - operandIn[7:0]) mod 256}, and accIn has no effect.
- R5: opSel 3'b101 is word negation. resultOut = {16'b0, (0 - operandIn[15:0]) mod 65536}.
- R6: After a negation, N is the top bit of the result at the active width (bit 7 or bit 15), and Z is 1 exactly when the result at that width is zero.
- R7: After a negation, V is 1 exactly when the operand at the active width is the most negative value (8'h80 or 16'h8000).
- R8: After a negation, C is 1 exactly when the operand at the active width is nonzero.
- R9: opSel 3'b000 and the reserved codes 3'b110 and 3'b111 leave resultOut and flagsOut unchanged and hold validOut low.
- R10: While rstN is low, resultOut, flagsOut and validOut are all zero.
- R11: validOut is high for exactly the cycle after each edge that sampled one of the five function codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opSel | input | 3 | Operation select |
| accIn | input | 32 | Accumulator value |
| operandIn | input | 32 | Second operand |
| flagsIn | input | 4 | Current flags {N,Z,V,C} |
| resultOut | output | 32 | Registered result |
| flagsOut | output | 4 | Registered updated flags {N,Z,V,C} |
| validOut | output | 1 | High in the cycle new result and flags are presented |

## Verification
The logic functions are driven with random operands and with directed patterns. The patterns pick out AND results of zero, results with bit 31 set, and both values of the incoming carry. Together they show that N and Z follow the result, that V is forced low, and that C passes straight through. Negation is tried at both widths with zero, the most negative value, one, all-ones, and operands whose upper bits are set outside the active width. These separate the V, C and Z rules and show that bits outside the width are ignored. Idle and reserved codes are placed between operations to show that the outputs hold.

// File: rtl/lnf_pkg.sv
package lnf_pkg;
  localparam int DATA_W = 32;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int OP_W   = 3;
  localparam int FLAG_W = 4;
  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_V = 1;
  localparam int FLAG_C = 0;

  typedef enum logic [OP_W-1:0] {
    OP_IDLE  = 3'b000,
    OP_AND   = 3'b001,
    OP_OR    = 3'b010,
    OP_XOR   = 3'b011,
    OP_NEGB  = 3'b100,
    OP_NEGW  = 3'b101,
    OP_RSV6  = 3'b110,
    OP_RSV7  = 3'b111
  } opCodeT;

  typedef enum logic [1:0] {
    FN_AND = 2'd0,
    FN_OR  = 2'd1,
    FN_XOR = 2'd2
  } logicFnT;

  typedef struct packed {
    logic    load;
    logic    doLogic;
    logic    doNeg;
    logic    negWord;
    logicFnT logicFn;
  } ctrlStrobesT;
endpackage

// File: rtl/lnf_ctrl.sv
module lnf_ctrl
  import lnf_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  output ctrlStrobesT     strobes
);
  always_comb begin
    strobes = '{load: 1'b0, doLogic: 1'b0, doNeg: 1'b0, negWord: 1'b0, logicFn: FN_AND};
    case (opCodeT'(opSel))
      OP_AND: begin strobes.load = 1'b1; strobes.doLogic = 1'b1; strobes.logicFn = FN_AND; end
      OP_OR:  begin strobes.load = 1'b1; strobes.doLogic = 1'b1; strobes.logicFn = FN_OR;  end
      OP_XOR: begin strobes.load = 1'b1; strobes.doLogic = 1'b1; strobes.logicFn = FN_XOR; end
      OP_NEGB: begin strobes.load = 1'b1; strobes.doNeg = 1'b1; end
      OP_NEGW: begin strobes.load = 1'b1; strobes.doNeg = 1'b1; strobes.negWord = 1'b1; end
      default: ;
    endcase
  end

  // R9: idle and reserved codes never raise any strobe
  always_comb begin
    if (opSel == 3'b000 || opSel[2:1] == 2'b11)
      a_idle_no_load_r9: assert (!strobes.load && !strobes.doLogic && !strobes.doNeg);
  end
endmodule

// File: rtl/lnf_datapath.sv
module lnf_datapath
  import lnf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [DATA_W-1:0] resultQ,
  output logic [FLAG_W-1:0] flagsQ,
  output logic              validQ
);
  localparam logic [BYTE_W-1:0] BYTE_MIN = {1'b1, {(BYTE_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] WORD_MIN = {1'b1, {(WORD_W-1){1'b0}}};

  logic [DATA_W-1:0] logicRes;
  logic [BYTE_W-1:0] negByte;
  logic [WORD_W-1:0] negWordRes;
  logic [DATA_W-1:0] resultD;
  logic [FLAG_W-1:0] flagsD;
  logic              negOpNonZero;
  logic              negOpMin;

  always_comb begin
    case (strobes.logicFn)
      FN_OR:   logicRes = accIn | operandIn;
      FN_XOR:  logicRes = accIn ^ operandIn;
      default: logicRes = accIn & operandIn;
    endcase
  end

  assign negByte    = BYTE_W'(~operandIn[BYTE_W-1:0]) + BYTE_W'(1);
  assign negWordRes = WORD_W'(~operandIn[WORD_W-1:0]) + WORD_W'(1);

  always_comb begin
    if (strobes.negWord) begin
      negOpNonZero = |operandIn[WORD_W-1:0];
      negOpMin     = (operandIn[WORD_W-1:0] == WORD_MIN);
    end else begin
      negOpNonZero = |operandIn[BYTE_W-1:0];
      negOpMin     = (operandIn[BYTE_W-1:0] == BYTE_MIN);
    end
  end

  always_comb begin
    resultD = resultQ;
    flagsD  = flagsQ;
    if (strobes.doLogic) begin
      resultD        = logicRes;
      flagsD[FLAG_N] = logicRes[DATA_W-1];
      flagsD[FLAG_Z] = (logicRes == '0);
      flagsD[FLAG_V] = 1'b0;
      flagsD[FLAG_C] = flagsIn[FLAG_C];
    end else if (strobes.doNeg) begin
      if (strobes.negWord) begin
        resultD        = {{(DATA_W-WORD_W){1'b0}}, negWordRes};
        flagsD[FLAG_N] = negWordRes[WORD_W-1];
        flagsD[FLAG_Z] = (negWordRes == '0);
      end else begin
        resultD        = {{(DATA_W-BYTE_W){1'b0}}, negByte};
        flagsD[FLAG_N] = negByte[BYTE_W-1];
        flagsD[FLAG_Z] = (negByte == '0);
      end
      flagsD[FLAG_V] = negOpMin;
      flagsD[FLAG_C] = negOpNonZero;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      flagsQ  <= '0;
      validQ  <= 1'b0;
    end else begin
      resultQ <= resultD;
      flagsQ  <= flagsD;
      validQ  <= strobes.load;
    end
  end

  p_logic_v_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doLogic |=> !flagsQ[FLAG_V]);

  p_logic_c_keep_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doLogic |=> flagsQ[FLAG_C] == $past(flagsIn[FLAG_C]));

  p_neg_zero_no_carry_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doNeg |=> (flagsQ[FLAG_Z] == !flagsQ[FLAG_C]));

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> ($stable(resultQ) && $stable(flagsQ) && !validQ));

  p_valid_follows_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> validQ);
endmodule

// File: rtl/logic_neg_flag_unit.sv
module logic_neg_flag_unit
  import lnf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [OP_W-1:0]   opSel,
  input  logic [DATA_W-1:0] accIn,
  input  logic [DATA_W-1:0] operandIn,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [DATA_W-1:0] resultOut,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              validOut
);
  ctrlStrobesT strobes;

  lnf_ctrl ctrl_i (
    .opSel   (opSel),
    .strobes (strobes)
  );

  lnf_datapath dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .accIn     (accIn),
    .operandIn (operandIn),
    .flagsIn   (flagsIn),
    .resultQ   (resultOut),
    .flagsQ    (flagsOut),
    .validQ    (validOut)
  );
endmodule

// File: tb/logic_neg_flag_unit_tb.sv
module logic_neg_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opSel = 3'b000;
  logic [31:0] accIn = '0;
  logic [31:0] operandIn = '0;
  logic [3:0]  flagsIn = '0;
  logic [31:0] resultOut;
  logic [3:0]  flagsOut;
  logic        validOut;

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] expRes = '0;
  logic [3:0]  expFlags = '0;
  bit doneFlag = 0;

  always #10 clk = ~clk;

  logic_neg_flag_unit dut_i (
    .clk(clk), .rstN(rstN), .opSel(opSel), .accIn(accIn),
    .operandIn(operandIn), .flagsIn(flagsIn),
    .resultOut(resultOut), .flagsOut(flagsOut), .validOut(validOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit isActive(input logic [2:0] op);
    return (op >= 3'b001 && op <= 3'b101);
  endfunction

  // Expected model built from the requirement text
  task automatic modelStep(input logic [2:0] op, input logic [31:0] a,
                           input logic [31:0] b, input logic [3:0] f);
    logic [31:0] r;
    int w;
    longint unsigned mask, opv, minv;
    case (op)
      3'b001, 3'b010, 3'b011: begin
        r = (op == 3'b001) ? (a & b) : (op == 3'b010) ? (a | b) : (a ^ b);
        expRes = r;
        expFlags = {r[31], (r == 0), 1'b0, f[0]};
      end
      3'b100, 3'b101: begin
        w = (op == 3'b100) ? 8 : 16;
        mask = (64'd1 << w) - 1;
        opv = b & mask;
        minv = 64'd1 << (w - 1);
        r = 32'((64'd0 - opv) & mask);
        expRes = r;
        expFlags = {r[w-1], (r == 0), (opv == minv), (opv != 0)};
      end
      default: ;
    endcase
  endtask

  task automatic runOp(input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] b, input logic [3:0] f);
    opSel = op; accIn = a; operandIn = b; flagsIn = f;
    modelStep(op, a, b, f);
    @(negedge clk);
    if (op inside {3'b001, 3'b010, 3'b011}) begin
      check("R1 logic result", resultOut, expRes);
      check("R2/R3 logic flags", {28'd0, flagsOut}, {28'd0, expFlags});
    end else if (op == 3'b100) begin
      check("R4 byte negate result", resultOut, expRes);
      check("R6/R7/R8 byte negate flags", {28'd0, flagsOut}, {28'd0, expFlags});
    end else if (op == 3'b101) begin
      check("R5 word negate result", resultOut, expRes);
      check("R6/R7/R8 word negate flags", {28'd0, flagsOut}, {28'd0, expFlags});
    end else begin
      check("R9 hold result", resultOut, expRes);
      check("R9 hold flags", {28'd0, flagsOut}, {28'd0, expFlags});
    end
    check("R11 valid strobe", {31'd0, validOut}, {31'd0, isActive(op)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!doneFlag) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R10 reset result", resultOut, 32'd0);
    check("R10 reset flags", {28'd0, flagsOut}, 32'd0);
    check("R10 reset valid", {31'd0, validOut}, 32'd0);
    rstN = 1'b1;

    // directed corners
    runOp(3'b001, 32'hF0F0_0000, 32'h0F0F_FFFF, 4'b0001);
    runOp(3'b010, 32'h8000_0000, 32'h0000_0001, 4'b0000);
    runOp(3'b011, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'b0001);
    runOp(3'b000, 32'h1234_5678, 32'h1, 4'b1111);
    runOp(3'b100, 32'hFFFF_FFFF, 32'hABCD_EF80, 4'b0000);
    runOp(3'b110, 32'h0, 32'h5, 4'b0000);
    runOp(3'b100, 32'h0, 32'hFFFF_FF00, 4'b1111);
    runOp(3'b100, 32'h0, 32'h0000_0001, 4'b0000);
    runOp(3'b111, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'b1111);
    runOp(3'b101, 32'h0, 32'h1234_8000, 4'b0000);
    runOp(3'b101, 32'h0, 32'hFFFF_0000, 4'b0000);
    runOp(3'b101, 32'h0, 32'h0000_FFFF, 4'b0000);
    runOp(3'b101, 32'h0, 32'h0000_0080, 4'b0000);

    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      runOp(op, $urandom, $urandom, 4'($urandom));
    end

    doneFlag = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule